// File: doc/BRIEF.md
# Byte and Word Arithmetic Unit with Condition Flags

This combinational unit computes one result and a set of five condition flags (negative N, overflow V, half-carry H, zero Z, carry C) for a small processor datapath. Byte operations cover add with carry, subtract with borrow, compare, the three bitwise logic functions, rotates through carry and plain shifts. Word operations cover add, subtract, compare, increment and decrement on a 16-bit register pair. The surrounding core supplies the operands, a 4-bit operation code and the current C and H flags. It writes each flag back only when that flag's write enable is high.

In subtraction, carry means "no borrow". The half-carry after any subtraction is the complement of the adder's bit-4 XOR term. Word operations take their half-carry from bit 4 of the word rather than from bit 12. A single parameterised add/subtract core is used twice, once at byte width and once at word width, and it produces carry, overflow and half-carry for both widths.

Top module: `flag_alu`

## Requirements
- R1: Op code 0 (byte add with carry) gives result a+b+C_in modulo 256, and C out is 1 exactly when a+b+C_in is 256 or more.
- R2: For op code 0, V is 1 when a and b have equal bit 7 and the result's bit 7 differs from it, and H equals bit 4 of (a XOR b XOR result).
- R3: Op code 1 (byte subtract with borrow) gives result a−b−(1−C_in) modulo 256, and C out is 1 exactly when that difference is not negative.
- R4: For op code 1, V is 1 when bit 7 of a and b differ and the result's bit 7 differs from a's, and H is the inverse of bit 4 of (a XOR b XOR result).
- R5: Op codes 2 (byte compare) and 12 (word compare) write only N, Z and C, from a−b with no carry-in: C is 1 when a ≥ b. The result output is 0.
- R6: Op code 10 (word add) ignores C_in, sets C when a+b is 0x10000 or more, takes V from bit 15 with the add rule and takes H from bit 4 of (a XOR b XOR result).
- R7: Op code 11 (word subtract) ignores C_in, sets C when a ≥ b, takes V from bit 15 with the subtract rule and H as the inverse of bit 4 of (a XOR b XOR result).
- R8: For every word result, N is bit 15 and Z is 1 only when all 16 bits are zero. For every byte result, N is bit 7 and Z is 1 only when the byte is zero.
- R9: Op codes 13 (increment) and 14 (decrement) add or subtract one modulo 0x10000 and write only N and Z.
- R10: Op codes 3, 4 and 5 (byte AND, OR, XOR) write only N and Z.
- R11: Op code 6 (rotate left) moves C_in into bit 0 and bit 7 into C. Op code 7 (rotate right) moves C_in into bit 7 and bit 0 into C. Both write N, Z and C.
- R12: Op code 8 (shift left) shifts a 0 into bit 0 and bit 7 into C. Op code 9 (shift right) shifts a 0 into bit 7 and bit 0 into C. Both write N, Z and C.
- R13: When a flag's write enable is low, the N, V and Z outputs are 0 and the C and H outputs repeat C_in and H_in. Op code 15 writes no flag and gives result 0.
- R14: Byte operations read only bits 7:0 of both operands and drive bits 15:8 of the result to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 16 | First operand (byte operations use bits 7:0) |
| b_i | input | 16 | Second operand (byte operations use bits 7:0) |
| c_i | input | 1 | Incoming carry flag |
| h_i | input | 1 | Incoming half-carry flag |
| res_o | output | 16 | Result |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Overflow flag |
| h_o | output | 1 | Half-carry flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| n_we_o | output | 1 | Negative flag write enable |
| v_we_o | output | 1 | Overflow flag write enable |
| h_we_o | output | 1 | Half-carry flag write enable |
| z_we_o | output | 1 | Zero flag write enable |
| c_we_o | output | 1 | Carry flag write enable |

## Verification
The byte add, subtract and compare paths are swept over every pair of operands with both carry-in values. This exposes a carry-in used with the wrong polarity in subtraction, which would shift every difference by one, and a half-carry left uninverted in subtraction, which would flip H on half of all vectors. Word operations run over a spread of patterns and sign-boundary corners (0x7FFF, 0x8000, 0xFFFF, 0x000F, 0x0010). A word zero flag taken from the low byte alone, or a half-carry taken from bit 12, fails on these. Every check also compares the enable vector and the high result byte with garbage in the operands' upper bytes. A compare that writes V or H, or a byte operation that leaks operand bits 15:8, therefore fails too.

// File: rtl/flag_alu_pkg.sv
// Shared operation codes and flag bundle for the flag ALU.
// Assumes a 4-bit operation code; code 15 is reserved and does nothing.
package flag_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADC8  = 4'd0,
        OP_SBC8  = 4'd1,
        OP_CMP8  = 4'd2,
        OP_AND8  = 4'd3,
        OP_OR8   = 4'd4,
        OP_XOR8  = 4'd5,
        OP_ROL8  = 4'd6,
        OP_ROR8  = 4'd7,
        OP_ASL8  = 4'd8,
        OP_LSR8  = 4'd9,
        OP_ADDW  = 4'd10,
        OP_SUBW  = 4'd11,
        OP_CMPW  = 4'd12,
        OP_INCW  = 4'd13,
        OP_DECW  = 4'd14,
        OP_NONE  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic h;
        logic z;
        logic c;
    } flag_set_t;

    typedef enum logic [2:0] {
        BIT_AND = 3'd0,
        BIT_OR  = 3'd1,
        BIT_XOR = 3'd2,
        BIT_ROL = 3'd3,
        BIT_ROR = 3'd4,
        BIT_ASL = 3'd5,
        BIT_LSR = 3'd6
    } bit_sel_e;

endpackage

// File: rtl/alu_addsub.sv
// Parameterised add/subtract core producing sum, carry, overflow and half-carry.
// Subtraction is a + ~b + cin, so carry out means "no borrow" and the bit-4
// half-carry term comes out already inverted relative to a ^ b ^ sum.
// Assumes N > 4 so that the half-carry tap at bit 4 exists.
module alu_addsub #(
    parameter int N = 8
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout,
    output logic         ovf,
    output logic         hc
);
    localparam int MSB = N - 1;
    localparam int HB  = 4;

    logic [N-1:0] b_eff;

    // Form the effective second operand and the full-width sum.
    always_comb begin
        b_eff       = sub ? ~b : b;
        {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{N{1'b0}}, cin};
        ovf         = ~(a[MSB] ^ b_eff[MSB]) & (a[MSB] ^ sum[MSB]);
        hc          = a[HB] ^ b_eff[HB] ^ sum[HB];
    end

endmodule

// File: rtl/alu_bitops.sv
// Byte logic, rotate-through-carry and shift unit.
// Assumes the caller masks flag writes; this block only returns result and carry.
module alu_bitops
    import flag_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  bit_sel_e     sel,
    output logic [W-1:0] res,
    output logic         cout
);
    // Pick the logic or shift function and its carry out.
    always_comb begin
        res  = '0;
        cout = cin;
        case (sel)
            BIT_AND: res = a & b;
            BIT_OR:  res = a | b;
            BIT_XOR: res = a ^ b;
            BIT_ROL: begin res = {a[W-2:0], cin};  cout = a[W-1]; end
            BIT_ROR: begin res = {cin, a[W-1:1]};  cout = a[0];   end
            BIT_ASL: begin res = {a[W-2:0], 1'b0}; cout = a[W-1]; end
            BIT_LSR: begin res = {1'b0, a[W-1:1]}; cout = a[0];   end
            default: begin res = '0; cout = cin; end
        endcase
    end

endmodule

// File: rtl/flag_alu.sv
// Byte/word ALU with N, V, H, Z, C flags and per-flag write enables.
// Purely combinational. Byte operations use the low W bits of the operands
// and clear the upper result bits. Unwritten N/V/Z read 0; unwritten C/H echo
// the incoming values.
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]     op_i,
    input  logic [2*W-1:0] a_i,
    input  logic [2*W-1:0] b_i,
    input  logic           c_i,
    input  logic           h_i,
    output logic [2*W-1:0] res_o,
    output logic           n_o,
    output logic           v_o,
    output logic           h_o,
    output logic           z_o,
    output logic           c_o,
    output logic           n_we_o,
    output logic           v_we_o,
    output logic           h_we_o,
    output logic           z_we_o,
    output logic           c_we_o
);
    localparam int WW = 2 * W;

    alu_op_e    op;
    logic       bsub, bcin, wsub, wcin;
    logic [WW-1:0] wb;
    logic [W-1:0]  bsum, lres;
    logic [WW-1:0] wsum;
    logic       bcout, bovf, bhc, wcout, wovf, whc, lcout;
    bit_sel_e   lsel;
    flag_set_t  val, we;
    logic [WW-1:0] res;

    // Steer operands and carry-in of both adders from the operation code.
    always_comb begin
        op   = alu_op_e'(op_i);
        bsub = (op != OP_ADC8);
        bcin = (op == OP_CMP8) ? 1'b1 : c_i;
        wsub = (op == OP_SUBW) || (op == OP_CMPW) || (op == OP_DECW);
        wcin = (op == OP_SUBW) || (op == OP_CMPW) || (op == OP_INCW);
        wb   = ((op == OP_INCW) || (op == OP_DECW)) ? '0 : b_i;
        case (op)
            OP_AND8: lsel = BIT_AND;
            OP_OR8:  lsel = BIT_OR;
            OP_XOR8: lsel = BIT_XOR;
            OP_ROL8: lsel = BIT_ROL;
            OP_ROR8: lsel = BIT_ROR;
            OP_ASL8: lsel = BIT_ASL;
            default: lsel = BIT_LSR;
        endcase
    end

    alu_addsub #(.N(W)) u_byte (
        .a(a_i[W-1:0]), .b(b_i[W-1:0]), .sub(bsub), .cin(bcin),
        .sum(bsum), .cout(bcout), .ovf(bovf), .hc(bhc)
    );

    alu_addsub #(.N(WW)) u_word (
        .a(a_i), .b(wb), .sub(wsub), .cin(wcin),
        .sum(wsum), .cout(wcout), .ovf(wovf), .hc(whc)
    );

    alu_bitops #(.W(W)) u_bits (
        .a(a_i[W-1:0]), .b(b_i[W-1:0]), .cin(c_i), .sel(lsel),
        .res(lres), .cout(lcout)
    );

    // Select result, raw flag values and write enables per operation.
    always_comb begin
        res = '0;
        val = '0;
        we  = '0;
        case (op)
            OP_ADC8, OP_SBC8: begin
                res = {{W{1'b0}}, bsum};
                val = '{n: bsum[W-1], v: bovf, h: bhc, z: (bsum == '0), c: bcout};
                we  = '{n: 1'b1, v: 1'b1, h: 1'b1, z: 1'b1, c: 1'b1};
            end
            OP_CMP8: begin
                val = '{n: bsum[W-1], v: 1'b0, h: 1'b0, z: (bsum == '0), c: bcout};
                we  = '{n: 1'b1, v: 1'b0, h: 1'b0, z: 1'b1, c: 1'b1};
            end
            OP_AND8, OP_OR8, OP_XOR8: begin
                res = {{W{1'b0}}, lres};
                val = '{n: lres[W-1], v: 1'b0, h: 1'b0, z: (lres == '0), c: 1'b0};
                we  = '{n: 1'b1, v: 1'b0, h: 1'b0, z: 1'b1, c: 1'b0};
            end
            OP_ROL8, OP_ROR8, OP_ASL8, OP_LSR8: begin
                res = {{W{1'b0}}, lres};
                val = '{n: lres[W-1], v: 1'b0, h: 1'b0, z: (lres == '0), c: lcout};
                we  = '{n: 1'b1, v: 1'b0, h: 1'b0, z: 1'b1, c: 1'b1};
            end
            OP_ADDW, OP_SUBW: begin
                res = wsum;
                val = '{n: wsum[WW-1], v: wovf, h: whc, z: (wsum == '0), c: wcout};
                we  = '{n: 1'b1, v: 1'b1, h: 1'b1, z: 1'b1, c: 1'b1};
            end
            OP_CMPW: begin
                val = '{n: wsum[WW-1], v: 1'b0, h: 1'b0, z: (wsum == '0), c: wcout};
                we  = '{n: 1'b1, v: 1'b0, h: 1'b0, z: 1'b1, c: 1'b1};
            end
            OP_INCW, OP_DECW: begin
                res = wsum;
                val = '{n: wsum[WW-1], v: 1'b0, h: 1'b0, z: (wsum == '0), c: 1'b0};
                we  = '{n: 1'b1, v: 1'b0, h: 1'b0, z: 1'b1, c: 1'b0};
            end
            default: begin
                res = '0;
                val = '0;
                we  = '0;
            end
        endcase
    end

    // Drive outputs, masking unwritten flags to 0 or the incoming value.
    always_comb begin
        res_o  = res;
        n_we_o = we.n;
        v_we_o = we.v;
        h_we_o = we.h;
        z_we_o = we.z;
        c_we_o = we.c;
        n_o    = we.n & val.n;
        v_o    = we.v & val.v;
        z_o    = we.z & val.z;
        h_o    = we.h ? val.h : h_i;
        c_o    = we.c ? val.c : c_i;
    end

    // Output-level consistency checks.
    always_comb begin
        // R13
        pass_carry_chk: assert (c_we_o || (c_o == c_i));
        // R14
        byte_high_clear_chk: assert ((op_i >= 4'd10) || (res_o[WW-1:W] == '0));
        // R5
        cmp_only_nzc_chk: assert (!((op_i == 4'd2) || (op_i == 4'd12)) ||
                                  (!v_we_o && !h_we_o && (res_o == '0)));
        // R8
        word_zero_chk: assert (!((op_i == 4'd10) || (op_i == 4'd11) ||
                                 (op_i == 4'd13) || (op_i == 4'd14)) ||
                               ((z_o == (res_o == '0)) && (n_o == res_o[WW-1])));
    end

endmodule

// File: tb/flag_alu_bench.sv
module flag_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'd15;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic        c_i = 1'b0;
    logic        h_i = 1'b0;
    logic [15:0] res_o;
    logic n_o, v_o, h_o, z_o, c_o;
    logic n_we_o, v_we_o, h_we_o, z_we_o, c_we_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    flag_alu u_flag_alu (
        .op_i(op_i), .a_i(a_i), .b_i(b_i), .c_i(c_i), .h_i(h_i),
        .res_o(res_o), .n_o(n_o), .v_o(v_o), .h_o(h_o), .z_o(z_o), .c_o(c_o),
        .n_we_o(n_we_o), .v_we_o(v_we_o), .h_we_o(h_we_o),
        .z_we_o(z_we_o), .c_we_o(c_we_o)
    );

    function automatic string req_of(input int op);
        case (op)
            0:  return "R1/R2/R8/R14";
            1:  return "R3/R4/R8/R14";
            2:  return "R5";
            3, 4, 5: return "R10/R8";
            6, 7: return "R11";
            8, 9: return "R12";
            10: return "R6/R8";
            11: return "R7/R8";
            12: return "R5";
            13, 14: return "R9/R8";
            default: return "R13";
        endcase
    endfunction

    // Expected {result, n, v, h, z, c, enables n v h z c}.
    function automatic logic [25:0] model(input int op, input int a, input int b,
                                          input bit c, input bit h);
        int x, y, d, r;
        bit n, v, hh, z, cc;
        logic [4:0] we;
        x = a & 255; y = b & 255;
        r = 0; n = 0; v = 0; hh = 0; z = 0; cc = 0; we = 5'b00000;
        case (op)
            0: begin
                d = x + y + int'(c); r = d & 255; cc = (d >= 256);
                v = ((x ^ y) & 128) == 0 && ((x ^ r) & 128) != 0;
                hh = ((x ^ y ^ r) & 16) != 0; we = 5'b11111;
            end
            1: begin
                d = x - y - (1 - int'(c)); r = d & 255; cc = (d >= 0);
                v = ((x ^ y) & 128) != 0 && ((x ^ r) & 128) != 0;
                hh = ((x ^ y ^ r) & 16) == 0; we = 5'b11111;
            end
            2: begin
                d = x - y; cc = (d >= 0); n = (d & 128) != 0; z = (d & 255) == 0;
                we = 5'b10011;
            end
            3: begin r = x & y; we = 5'b10010; end
            4: begin r = x | y; we = 5'b10010; end
            5: begin r = x ^ y; we = 5'b10010; end
            6: begin r = ((x << 1) | int'(c)) & 255; cc = (x >> 7) != 0; we = 5'b10011; end
            7: begin r = (x >> 1) | (int'(c) << 7);   cc = (x & 1) != 0;  we = 5'b10011; end
            8: begin r = (x << 1) & 255;              cc = (x >> 7) != 0; we = 5'b10011; end
            9: begin r = x >> 1;                      cc = (x & 1) != 0;  we = 5'b10011; end
            10: begin
                x = a & 65535; y = b & 65535; d = x + y; r = d & 65535; cc = (d >= 65536);
                v = ((x ^ y) & 32768) == 0 && ((x ^ r) & 32768) != 0;
                hh = ((x ^ y ^ r) & 16) != 0; we = 5'b11111;
            end
            11: begin
                x = a & 65535; y = b & 65535; d = x - y; r = d & 65535; cc = (d >= 0);
                v = ((x ^ y) & 32768) != 0 && ((x ^ r) & 32768) != 0;
                hh = ((x ^ y ^ r) & 16) == 0; we = 5'b11111;
            end
            12: begin
                x = a & 65535; y = b & 65535; d = x - y; cc = (d >= 0);
                n = (d & 32768) != 0; z = (d & 65535) == 0; we = 5'b10011;
            end
            13: begin r = ((a & 65535) + 1) & 65535; we = 5'b10010; end
            14: begin r = ((a & 65535) - 1) & 65535; we = 5'b10010; end
            default: begin r = 0; we = 5'b00000; end
        endcase
        if (op != 2 && op != 12 && op <= 9 && we[4]) begin
            n = (r & 128) != 0; z = (r == 0);
        end else if (op >= 10 && op <= 14 && op != 12) begin
            n = (r & 32768) != 0; z = (r == 0);
        end
        if (!we[2]) hh = h;
        if (!we[0]) cc = c;
        return {r[15:0], n, v, hh, z, cc, we};
    endfunction

    task automatic apply(input int op, input int a, input int b, input bit c, input bit h);
        logic [25:0] exp, got;
        op_i = op[3:0]; a_i = a[15:0]; b_i = b[15:0]; c_i = c; h_i = h;
        #1;
        exp = model(op, a, b, c, h);
        got = {res_o, n_o, v_o, h_o, z_o, c_o, n_we_o, v_we_o, h_we_o, z_we_o, c_we_o};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h c=%0d h=%0d got=%h expected=%h",
                     req_of(op), op, a[15:0], b[15:0], c, h, got, exp);
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int corners[7] = '{0, 1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h000F, 16'h0010};
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R13: reserved code, idle state, nothing written and result 0
        apply(15, 0, 0, 0, 0);
        apply(15, 16'hFFFF, 16'h1234, 1, 1);
        // R1 R2 R3 R4 R14: full byte sweep with garbage upper operand bytes
        for (int op = 0; op <= 1; op++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    for (int c = 0; c < 2; c++)
                        apply(op, ((a ^ 8'h5A) << 8) | a, ((b ^ 8'hC3) << 8) | b,
                              bit'(c), bit'(c ^ (a & 1)));
        // R5: byte compare, carry-in varied to show it is ignored
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                apply(2, ((a + 3) << 8) | a, b, bit'((a ^ b) & 1), bit'(b & 1));
        // R10 R11 R12: logic, rotates and shifts
        for (int op = 3; op <= 9; op++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b += 9)
                    for (int c = 0; c < 2; c++)
                        apply(op, (b << 8) | a, (a << 8) | b, bit'(c), bit'(~c & 1));
        // R6 R7 R5 R9 R8: word patterns
        for (int i = 0; i < 4096; i++) begin
            int a, b;
            a = ((i * 40503) ^ (i << 3)) & 65535;
            b = (~(i * 32586) ^ (i >> 2)) & 65535;
            for (int op = 10; op <= 14; op++)
                apply(op, a, b, bit'(i & 1), bit'((i >> 1) & 1));
        end
        // R6 R7 R5 R9 R8: sign-boundary and half-carry corners
        foreach (corners[i])
            foreach (corners[j])
                for (int c = 0; c < 2; c++)
                    for (int op = 10; op <= 14; op++)
                        apply(op, corners[i], corners[j], bit'(c), bit'(c));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule